// File: doc/BRIEF.md
# Split-Frame SPI Register Slave with Ready Stall

This block is an SPI slave that gives an external master access to an on-chip register space. Every access takes two chip-select frames. The first frame carries a 16-bit header that selects an operation, a channel and a register address. The second frame carries the 16-bit data word. Between the two frames, an active-low ready line (`ena_n`) tells the master when it may start shifting the data word.

Only a complete header tells the slave which register is the target. Once it has one, the slave compares that register with the one that internal logic is updating at the moment. If they match, it holds `ena_n` high until the update has finished. A read copies the register into the outgoing shift register in the same cycle that ready goes low, so the word leaves on MISO with no latency byte. Later internal updates cannot change it. A write is handed to the register port as a one-cycle strobe when chip select rises, provided the frame held exactly 16 bits.

The SPI pins are asynchronous to `clk` and pass through two-flop synchronisers. The master must therefore keep each SCLK level for at least four `clk` cycles.

Top module: `spi_hdr_slave`

## Requirements
- R1: A header frame holds exactly 16 bits: opcode in bits [15:12], channel in bits [11:8] and address in bits [7:0]. A header frame with any other bit count is discarded. After a valid read or write header, `acc_chan` and `acc_addr` show the decoded fields.
- R2: The bus runs in SPI mode 0 with MSB first. MOSI is sampled on the rising SCLK edge, and MISO moves to the next bit on the falling SCLK edge.
- R3: `ena_n` is high after reset and while a header is awaited. After a valid read (opcode 0) or write (opcode 1) header with no collision, it goes low within a few cycles.
- R4: While `upd_busy` is high and `upd_chan`/`upd_addr` equal the decoded target, `ena_n` stays high. It goes low once that condition clears. A busy update on any other register does not stall.
- R5: A read returns the `rd_data` value from the cycle in which `ena_n` fell. Changes to `rd_data` after that cycle do not reach MISO.
- R6: After a write header, a data frame of exactly 16 bits produces a single one-cycle `wr_en` pulse after chip select rises. `wr_data` holds the received word, and `acc_chan`/`acc_addr` hold the target.
- R7: A data frame with a bit count other than 16 produces no `wr_en`. The slave then waits for a new header.
- R8: Opcode 2 pulses `clr_en` for one cycle, with `acc_chan` holding the channel. It does not assert `ena_n` and expects no data frame.
- R9: Opcodes other than 0, 1 and 2 are ignored: no ready, no write strobe and no clear strobe.
- R10: `miso_oe` is low whenever chip select has been high for more than three cycles, and high during a frame.
- R11: `ena_n` returns high after the data frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock from master |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Master-out serial data |
| miso | output | 1 | Slave-out serial data |
| miso_oe | output | 1 | Output enable for MISO; pad is high-impedance when low |
| ena_n | output | 1 | Active-low ready to master |
| acc_chan | output | 4 | Decoded target channel |
| acc_addr | output | 8 | Decoded target register address |
| rd_data | input | DW | Register value at `acc_chan`/`acc_addr` |
| wr_en | output | 1 | One-cycle write strobe |
| wr_data | output | DW | Write data word |
| clr_en | output | 1 | One-cycle channel-reset strobe |
| upd_busy | input | 1 | Internal logic is updating a register |
| upd_chan | input | 4 | Channel under internal update |
| upd_addr | input | 8 | Address under internal update |

## Verification
The assertions assume a master that follows the split-frame protocol:
- It holds each SCLK level long enough for the synchronisers to see every edge.
- It raises chip select between header and data.
- It shifts no data bits before `ena_n` is low.

They also assume that the register port's `rd_data` is a combinational function of `acc_chan`/`acc_addr`. The bench keeps to these rules. Its master task holds each SCLK level for four clock cycles and waits on `ena_n` before clocking the data word. It changes `upd_busy` and its modelled register contents only while SCLK is idle.

// File: rtl/spi_hdr_slave.sv
module spi_hdr_slave #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          mosi,
  output logic          miso,
  output logic          miso_oe,
  output logic          ena_n,
  output logic [3:0]    acc_chan,
  output logic [7:0]    acc_addr,
  input  logic [DW-1:0] rd_data,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output logic          clr_en,
  input  logic          upd_busy,
  input  logic [3:0]    upd_chan,
  input  logic [7:0]    upd_addr
);
  localparam int RW = (DW > 16) ? DW : 16;
  localparam int CW = $clog2(RW + 1) + 1;
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [CW-1:0] HBITS = CW'(16);
  localparam logic [CW-1:0] DBITS = CW'(DW);

  typedef enum logic [1:0] {S_HDR, S_WAIT, S_DATA} st_t;

  st_t           st;
  logic [2:0]    sck_q, cs_q;
  logic [1:0]    mo_q;
  logic [CW-1:0] cnt;
  logic [RW-1:0] rx;
  logic [DW-1:0] tx;
  logic          is_wr;

  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire sck_fall = ~sck_q[1] & sck_q[2];
  wire cs_lo    = ~cs_q[1];
  wire cs_fall  = ~cs_q[1] & cs_q[2];
  wire cs_rise  = cs_q[1] & ~cs_q[2];
  wire [3:0] hop = rx[15:12];
  wire collide  = upd_busy && (upd_chan == acc_chan) && (upd_addr == acc_addr);

  assign miso    = tx[DW-1];
  assign miso_oe = cs_lo;
  assign ena_n   = (st != S_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      cs_q  <= '1;
      mo_q  <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sclk};
      cs_q  <= {cs_q[1:0], cs_n};
      mo_q  <= {mo_q[0], mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      rx  <= '0;
    end else begin
      if (cs_fall)
        cnt <= '0;
      else if (cs_lo && sck_rise && cnt != CMAX)
        cnt <= cnt + 1'b1;
      if (cs_lo && sck_rise)
        rx <= {rx[RW-2:0], mo_q[1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_HDR;
      acc_chan <= '0;
      acc_addr <= '0;
      is_wr    <= 1'b0;
      tx       <= '0;
      wr_en    <= 1'b0;
      wr_data  <= '0;
      clr_en   <= 1'b0;
    end else begin
      wr_en  <= 1'b0;
      clr_en <= 1'b0;
      case (st)
        S_HDR: begin
          if (cs_rise && cnt == HBITS) begin
            if (hop == 4'd0 || hop == 4'd1) begin
              acc_chan <= rx[11:8];
              acc_addr <= rx[7:0];
              is_wr    <= (hop == 4'd1);
              st       <= S_WAIT;
            end else if (hop == 4'd2) begin
              acc_chan <= rx[11:8];
              acc_addr <= rx[7:0];
              clr_en   <= 1'b1;
            end
          end
        end
        S_WAIT: begin
          if (cs_rise)
            st <= S_HDR;
          else if (!collide) begin
            tx <= is_wr ? '0 : rd_data;
            st <= S_DATA;
          end
        end
        S_DATA: begin
          if (cs_rise) begin
            st <= S_HDR;
            tx <= '0;
            if (is_wr && cnt == DBITS) begin
              wr_en   <= 1'b1;
              wr_data <= rx[DW-1:0];
            end
          end else if (cs_lo && sck_fall) begin
            tx <= {tx[DW-2:0], 1'b0};
          end
        end
        default: st <= S_HDR;
      endcase
    end
  end
endmodule

module spi_hdr_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       miso_oe,
  input logic       ena_n,
  input logic       wr_en,
  input logic       clr_en,
  input logic [3:0] acc_chan,
  input logic [7:0] acc_addr,
  input logic       upd_busy,
  input logic [3:0] upd_chan,
  input logic [7:0] upd_addr
);
  AST_OE_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso_oe); // R10
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R6
  AST_WR_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(!ena_n) && ena_n)); // R11
  AST_READY_NO_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ena_n) |-> !($past(upd_busy) && $past(upd_chan) == acc_chan && $past(upd_addr) == acc_addr)); // R4
  AST_CLR_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> (ena_n && !wr_en)); // R8
  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !clr_en); // R8
endmodule

bind spi_hdr_slave spi_hdr_slave_chk u_chk (.*);

// File: tb/sim_spi_hdr_slave.sv
`timescale 1ns/1ps
module sim_spi_hdr_slave;
  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, mosi = 0;
  logic miso, miso_oe, ena_n, wr_en, clr_en;
  logic [3:0] acc_chan, upd_chan = 0;
  logic [7:0] acc_addr, upd_addr = 0;
  logic [15:0] rd_data, wr_data, salt = 16'h0;
  logic upd_busy = 0;
  int total = 0, bad = 0, wr_cnt = 0, clr_cnt = 0, cs_hi = 0;
  logic [3:0] last_chan;
  logic [7:0] last_addr;
  logic [15:0] last_data, got;
  logic oe_in_frame;

  always #2.5 clk = ~clk;

  assign rd_data = {acc_chan, acc_addr, 4'h0} ^ salt;

  spi_hdr_slave #(.DW(16)) u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .ena_n(ena_n),
    .acc_chan(acc_chan), .acc_addr(acc_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_data(wr_data), .clr_en(clr_en),
    .upd_busy(upd_busy), .upd_chan(upd_chan), .upd_addr(upd_addr));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en) begin
        wr_cnt++; last_chan = acc_chan; last_addr = acc_addr; last_data = wr_data;
      end
      if (clr_en) begin
        clr_cnt++; last_chan = acc_chan;
      end
      cs_hi = cs_n ? cs_hi + 1 : 0;
      if (cs_hi > 4) chk(miso_oe == 1'b0, "R10 oe idle", miso_oe, 0);
    end
  end

  task automatic frame(input int nbits, input logic [15:0] w, input bit wait_ena);
    int lim = 0;
    cs_n = 0;
    cyc(4);
    if (wait_ena)
      while (ena_n && lim < 2000) begin cyc(1); lim++; end
    oe_in_frame = miso_oe;
    got = '0;
    for (int i = 0; i < nbits; i++) begin
      mosi = w[15-i];
      cyc(4);
      got = {got[14:0], miso};
      sclk = 1;
      cyc(4);
      sclk = 0;
    end
    cyc(4);
    cs_n = 1;
    cyc(10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w0, c0;
    logic [15:0] exp;
    cyc(4); rst_n = 1; cyc(4);
    chk(ena_n == 1, "R3 reset ena_n", ena_n, 1);
    chk(miso_oe == 0, "R10 reset oe", miso_oe, 0);
    chk(wr_en == 0 && clr_en == 0, "R6 reset strobes", {wr_en, clr_en}, 0);

    // plain read
    salt = 16'h5a5a;
    frame(16, {4'd0, 4'd3, 8'h21}, 0);
    chk(ena_n == 0, "R3 ready after read header", ena_n, 0);
    chk(acc_chan == 3 && acc_addr == 8'h21, "R1 decode", {acc_chan, acc_addr}, 12'h321);
    frame(16, 16'h0, 1);
    chk(oe_in_frame == 1, "R10 oe in frame", oe_in_frame, 1);
    chk(got == ({4'h3, 8'h21, 4'h0} ^ 16'h5a5a), "R2 read word", got, {4'h3, 8'h21, 4'h0} ^ 16'h5a5a);
    chk(ena_n == 1, "R11 ready released", ena_n, 1);

    // write
    w0 = wr_cnt;
    frame(16, {4'd1, 4'd5, 8'h40}, 0);
    frame(16, 16'hbeef, 1);
    chk(wr_cnt == w0 + 1, "R6 write count", wr_cnt, w0 + 1);
    chk(last_data == 16'hbeef && last_chan == 5 && last_addr == 8'h40, "R6 write fields",
        {last_chan, last_addr, last_data}, {4'd5, 8'h40, 16'hbeef});

    // collision stall
    upd_busy = 1; upd_chan = 7; upd_addr = 8'h10;
    frame(16, {4'd0, 4'd7, 8'h10}, 0);
    cyc(40);
    chk(ena_n == 1, "R4 stall on collision", ena_n, 1);
    salt = 16'h1234;
    upd_busy = 0;
    cyc(6);
    chk(ena_n == 0, "R4 ready after update", ena_n, 0);
    exp = {4'h7, 8'h10, 4'h0} ^ 16'h1234;
    salt = 16'hffff;
    frame(16, 16'h0, 1);
    chk(got == exp, "R5 snapshot kept", got, exp);

    // busy elsewhere
    upd_busy = 1; upd_chan = 7; upd_addr = 8'h11;
    frame(16, {4'd0, 4'd7, 8'h10}, 0);
    chk(ena_n == 0, "R4 no stall other addr", ena_n, 0);
    upd_busy = 0;
    frame(16, 16'h0, 1);

    // short header
    w0 = wr_cnt;
    frame(12, {4'd1, 4'd2, 8'h33}, 0);
    chk(ena_n == 1, "R1 short header dropped", ena_n, 1);
    frame(16, {4'd1, 4'd2, 8'h33}, 0);
    chk(ena_n == 0, "R1 valid header after drop", ena_n, 0);
    frame(15, 16'h7777, 1);
    chk(wr_cnt == w0, "R7 short data no write", wr_cnt, w0);
    chk(ena_n == 1, "R7 back to header", ena_n, 1);
    frame(16, {4'd0, 4'd1, 8'h02}, 0);
    chk(ena_n == 0, "R7 header accepted after", ena_n, 0);
    frame(16, 16'h0, 1);

    // clear channel
    c0 = clr_cnt; w0 = wr_cnt;
    frame(16, {4'd2, 4'd9, 8'h00}, 0);
    chk(clr_cnt == c0 + 1 && last_chan == 9, "R8 clear strobe", {clr_cnt[7:0], last_chan}, {8'(c0 + 1), 4'd9});
    chk(ena_n == 1, "R8 no ready on clear", ena_n, 1);

    // undefined opcode
    c0 = clr_cnt;
    frame(16, {4'hf, 4'd4, 8'h44}, 0);
    cyc(10);
    chk(ena_n == 1 && clr_cnt == c0 && wr_cnt == w0, "R9 undefined opcode",
        {ena_n, clr_cnt[7:0], wr_cnt[7:0]}, {1'b1, c0[7:0], w0[7:0]});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule